// File: doc/BRIEF.md
# Banked GPIO Pin Configuration Register Block

This block holds the configuration for several banks of 32 general-purpose pins. It decodes a single-cycle register bus, which carries a byte address, a write strobe, 32-bit write data and combinational read data. The per-pin settings it stores go straight to the pads: the function select, the output value, the output enable, the drive strength and the pull control. Pad input levels pass through a two-flop synchronizer before software can read them.

Each bank has nine 32-bit words. The per-pin fields have different widths, so each kind of field packs a different number of pins into a word. Banks repeat every 0x24 bytes, which is not a power of two, so the decoder compares the address against a range for each bank instead of slicing address bits. A separate word holds one voltage-mode bit per bank.

Top module: `gpio_bank_regs`

## Requirements
- R1: Function select is 4 bits per pin, 8 pins per word. The words sit at bank offsets 0x00, 0x04, 0x08 and 0x0C. Pin n uses word n/8, bits (n%8)*4+3 down to (n%8)*4, and that field drives `pin_func[(bank*32+n)*4 +: 4]`.
- R2: The output-value word is at bank offset 0x10, with pin n at bit n. Bit n drives `pad_out[bank*32+n]`.
- R3: Drive strength is 2 bits per pin, 16 pins per word, at bank offsets 0x14 (pins 0-15) and 0x18 (pins 16-31). Pin n uses bits (n%16)*2+1 down to (n%16)*2 and drives `pin_drive[(bank*32+n)*2 +: 2]`.
- R4: Pull control is 2 bits per pin, 16 pins per word, at bank offsets 0x1C (pins 0-15) and 0x20 (pins 16-31). It uses the same bit placement as drive strength and drives `pin_pull[(bank*32+n)*2 +: 2]`.
- R5: The words of bank k start at byte address k*0x24, and every bank has the same layout.
- R6: The voltage-mode word is at address `VMODE_ADDR`, with bank k at bit k. A write loads those bits, which drive `bank_vmode`. A read returns them, with zero in every bit above the bank count.
- R7: `pad_oe` for a pin is 1 exactly when that pin's function field equals 1. Every other function value (0 = input, 2..15 = alternate functions) leaves the output disabled.
- R8: Reading offset 0x10 returns, for each pin, the stored output value if its function field is 1. Otherwise it returns the pad level. The pad level is delayed by two clock edges through the synchronizer.
- R9: After reset, every word, every synchronizer stage and every voltage-mode bit is zero. All pins are therefore inputs, with pull off and the lowest drive.
- R10: An address that is not word-aligned, that lies beyond the last bank, or that is not `VMODE_ADDR` reads as zero. A write to such an address changes no output and no stored word.
- R11: A write replaces the whole addressed word on the next clock edge. Reading a function, drive or pull word afterwards returns exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_BANKS*32 | Pad input levels, asynchronous |
| pad_out | output | NUM_BANKS*32 | Output value per pin |
| pad_oe | output | NUM_BANKS*32 | Output enable per pin |
| pin_func | output | NUM_BANKS*128 | Function select per pin, 4 bits each |
| pin_drive | output | NUM_BANKS*64 | Drive strength per pin, 2 bits each |
| pin_pull | output | NUM_BANKS*64 | Pull control per pin, 2 bits each |
| bank_vmode | output | NUM_BANKS | Voltage-mode select per bank |

## Verification
The bench builds the block with three banks and the voltage-mode word at 0x080. This puts the last bank at 0x48-0x6B, so the addresses just past it fall in a gap before the voltage-mode word. It also makes the range decode at the 0x24 stride meet a bank count that is not a power of two. Random write data is often restricted to values 0 and 1 in each nibble, so that function fields frequently select output mode and exercise the read path that mixes stored and pad values. Unaligned, out-of-range and voltage-mode addresses are mixed with bank addresses on every run.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] VMODE_ADDR = 12'h200
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_BANKS*32-1:0]   pad_in,
  output logic [NUM_BANKS*32-1:0]   pad_out,
  output logic [NUM_BANKS*32-1:0]   pad_oe,
  output logic [NUM_BANKS*128-1:0]  pin_func,
  output logic [NUM_BANKS*64-1:0]   pin_drive,
  output logic [NUM_BANKS*64-1:0]   pin_pull,
  output logic [NUM_BANKS-1:0]      bank_vmode
);
  localparam int WORDS = 9;
  localparam int STRIDE = WORDS * 4;
  localparam int TOTAL = NUM_BANKS * WORDS;
  localparam int FLAT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int DATA_WORD = 4;

  logic [31:0] regs_q [TOTAL];
  logic [NUM_BANKS*32-1:0] sync1_q, sync2_q, data_rd;
  logic [NUM_BANKS-1:0] vmode_q;

  logic hit, vmode_hit, aligned;
  logic [FLAT_W-1:0] flat;
  logic [BANK_W-1:0] bank_idx;
  logic [3:0] word_idx;
  logic [ADDR_W-1:0] off;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign vmode_hit = aligned && (bus_addr == VMODE_ADDR);

  always_comb begin
    hit = 1'b0;
    flat = '0;
    bank_idx = '0;
    word_idx = '0;
    off = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (bus_addr >= ADDR_W'(k*STRIDE) && bus_addr < ADDR_W'((k+1)*STRIDE)) begin
        off = bus_addr - ADDR_W'(k*STRIDE);
        hit = aligned;
        bank_idx = BANK_W'(k);
        word_idx = off[5:2];
        flat = FLAT_W'(k*WORDS) + FLAT_W'(off[5:2]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) regs_q[i] <= '0;
    end else if (bus_we && hit) begin
      regs_q[flat] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vmode_q <= '0;
    else if (bus_we && vmode_hit) vmode_q <= bus_wdata[NUM_BANKS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar w = 0; w < 4; w++) begin : g_func
      assign pin_func[b*128 + w*32 +: 32] = regs_q[b*WORDS + w];
    end
    assign pad_out[b*32 +: 32] = regs_q[b*WORDS + DATA_WORD];
    assign pin_drive[b*64 +: 64] = {regs_q[b*WORDS + 6], regs_q[b*WORDS + 5]};
    assign pin_pull[b*64 +: 64] = {regs_q[b*WORDS + 8], regs_q[b*WORDS + 7]};
    for (genvar p = 0; p < 32; p++) begin : g_pin
      assign pad_oe[b*32 + p] = (pin_func[(b*32 + p)*4 +: 4] == 4'd1);
      assign data_rd[b*32 + p] = pad_oe[b*32 + p] ? pad_out[b*32 + p] : sync2_q[b*32 + p];
    end
  end

  assign bank_vmode = vmode_q;

  always_comb begin
    bus_rdata = '0;
    if (vmode_hit) bus_rdata = 32'(vmode_q);
    else if (hit) bus_rdata = (word_idx == 4'(DATA_WORD)) ? data_rd[bank_idx*32 +: 32] : regs_q[flat];
  end

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  p_write_replaces_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit) |=> regs_q[$past(flat)] == $past(bus_wdata));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !vmode_hit) |-> bus_rdata == 32'd0);

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> sync2_q == $past(pad_in, 2));

  p_oe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pad_oe));

  p_vmode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && vmode_hit) |=> $stable(bank_vmode));
endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
  localparam int NB = 3;
  localparam int AW = 12;
  localparam logic [AW-1:0] VADDR = 12'h080;
  localparam int NP = NB * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NB*128-1:0] pin_func;
  logic [NB*64-1:0] pin_drive, pin_pull;
  logic [NB-1:0] bank_vmode;

  always #4 clk = ~clk;

  gpio_bank_regs #(.NUM_BANKS(NB), .ADDR_W(AW), .VMODE_ADDR(VADDR)) i_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_func(pin_func), .pin_drive(pin_drive), .pin_pull(pin_pull), .bank_vmode(bank_vmode));

  int total = 0;
  int bad = 0;

  logic [31:0] m [NB*9];
  logic [NB-1:0] vm;
  logic [NP-1:0] s1, s2;

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int bank_of(logic [AW-1:0] a);
    int ai = int'(a);
    if (a[1:0] != 2'b00) return -1;
    if (ai >= NB*36) return -1;
    return ai / 36;
  endfunction

  function automatic logic [3:0] fn_of(int pin);
    int b = pin / 32;
    int n = pin % 32;
    logic [31:0] w = m[b*9 + n/8];
    return w[(n%8)*4 +: 4];
  endfunction

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    int b, r;
    logic [31:0] v;
    if (a[1:0] == 2'b00 && a == VADDR) return 32'(vm);
    b = bank_of(a);
    if (b < 0) return 32'd0;
    r = (int'(a) - b*36) / 4;
    if (r != 4) return m[b*9 + r];
    for (int n = 0; n < 32; n++) begin
      logic [31:0] d = m[b*9 + 4];
      v[n] = (fn_of(b*32 + n) == 4'd1) ? d[n] : s2[b*32 + n];
    end
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NB*9; i++) m[i] = '0;
    vm = '0; s1 = '0; s2 = '0;
  endtask

  task automatic model_step();
    int b;
    if (bus_we) begin
      if (bus_addr[1:0] == 2'b00 && bus_addr == VADDR) vm = bus_wdata[NB-1:0];
      else begin
        b = bank_of(bus_addr);
        if (b >= 0) m[b*9 + (int'(bus_addr) - b*36)/4] = bus_wdata;
      end
    end
    s2 = s1;
    s1 = pad_in;
  endtask

  task automatic check_state();
    logic [NB*128-1:0] ef;
    logic [NB*64-1:0] ed, ep;
    logic [NP-1:0] eo, ee;
    for (int p = 0; p < NP; p++) begin
      int b = p / 32;
      int n = p % 32;
      logic [31:0] dw = m[b*9 + 5 + n/16];
      logic [31:0] pw = m[b*9 + 7 + n/16];
      logic [31:0] ow = m[b*9 + 4];
      ef[p*4 +: 4] = fn_of(p);
      ed[p*2 +: 2] = dw[(n%16)*2 +: 2];
      ep[p*2 +: 2] = pw[(n%16)*2 +: 2];
      eo[p] = ow[n];
      ee[p] = (fn_of(p) == 4'd1);
    end
    chk("R1 pin_func", 512'(pin_func), 512'(ef));
    chk("R2 pad_out", 512'(pad_out), 512'(eo));
    chk("R3 pin_drive", 512'(pin_drive), 512'(ed));
    chk("R4 pin_pull", 512'(pin_pull), 512'(ep));
    chk("R7 pad_oe", 512'(pad_oe), 512'(ee));
    chk("R6 bank_vmode", 512'(bank_vmode), 512'(vm));
  endtask

  task automatic check_read();
    int b = bank_of(bus_addr);
    string tag;
    if (bus_addr[1:0] == 2'b00 && bus_addr == VADDR) tag = "R6 read";
    else if (b < 0) tag = "R10 read";
    else if ((int'(bus_addr) - b*36) / 4 == 4) tag = "R8 read";
    else if (b > 0) tag = "R5 read";
    else tag = "R11 read";
    chk(tag, 512'(bus_rdata), 512'(exp_read(bus_addr)));
  endtask

  task automatic cycle(logic [AW-1:0] a, logic we, logic [31:0] wd, logic [NP-1:0] pin);
    @(negedge clk);
    model_step();
    check_state();
    bus_addr = a; bus_we = we; bus_wdata = wd; pad_in = pin;
    #1;
    check_read();
  endtask

  function automatic logic [NP-1:0] rnd_pads();
    logic [NP-1:0] v;
    for (int i = 0; i < NP; i += 32) v[i +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    bus_addr = 12'h000;
    #1;
    chk("R9 reset read func", 512'(bus_rdata), 512'(0));
    chk("R9 reset oe", 512'(pad_oe), 512'(0));
    chk("R9 reset drive", 512'(pin_drive), 512'(0));
    chk("R9 reset vmode", 512'(bank_vmode), 512'(0));
    rst_n = 1'b1;
    // R1/R7: pin 7 of bank 0 to output, R2 drive it high, R8 read back
    cycle(12'h000, 1'b1, 32'h1000_0000, '0);
    cycle(12'h010, 1'b1, 32'h0000_0080, '0);
    cycle(12'h010, 1'b0, 32'h0, {NP{1'b1}});
    cycle(12'h010, 1'b0, 32'h0, {NP{1'b1}});
    cycle(12'h010, 1'b0, 32'h0, {NP{1'b1}});
    // R5: last bank data, R3/R4 top halves
    cycle(12'h048 + 12'h018, 1'b1, 32'hC000_0001, '0);
    cycle(12'h048 + 12'h020, 1'b1, 32'h8000_0002, '0);
    // R10: just past last bank, unaligned, R6 voltage bits
    cycle(12'h06C, 1'b1, 32'hFFFF_FFFF, '0);
    cycle(12'h049, 1'b1, 32'hFFFF_FFFF, '0);
    cycle(VADDR, 1'b1, 32'hFFFF_FFFF, '0);
    cycle(VADDR, 1'b0, 32'h0, '0);
    cycle(VADDR, 1'b1, 32'h0000_0002, '0);
    cycle(VADDR, 1'b0, 32'h0, '0);
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom % 10;
      logic [AW-1:0] a;
      logic [31:0] wd;
      case (sel)
        0, 1, 2, 3, 4, 5: a = AW'(($urandom % NB) * 36 + ($urandom % 9) * 4);
        6: a = AW'(($urandom % NB) * 36 + ($urandom % 9) * 4 + 1 + $urandom % 3);
        7: a = AW'(NB * 36 + ($urandom % 4) * 4);
        8: a = VADDR;
        default: a = AW'($urandom);
      endcase
      wd = ($urandom % 2) ? $urandom : ($urandom & 32'h1111_1111);
      cycle(a, 1'($urandom % 2), wd, rnd_pads());
    end
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule